// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block drives two 8-bit output channels toward peripherals. Each channel has a handshake. A CPU write latches a byte onto the channel's data pins and pulls the channel's active-low buffer-full line low, which tells the device that a new byte is waiting. The device confirms that it has taken the byte by pulsing its active-low acknowledge. The falling edge of the acknowledge releases buffer-full. The rising edge raises an interrupt request asking the CPU for the next byte, provided that the channel's interrupt enable is set.

The CPU reaches the block over one small write bus with a 2-bit select. Select 0 writes channel A data and select 1 writes channel B data. Select 2 writes the general-purpose status-port bits. Select 3 writes a control byte, and a control byte with bit 7 clear sets or clears one status-port bit. The interrupt enables are only reachable this way: status-port bit 6 holds the enable for A and bit 2 holds the enable for B. Bits 4 and 5 are spare general-purpose outputs. An 8-bit status view gathers the handshake state of both channels into a single byte. The acknowledge inputs are asynchronous and pass through a two-stage synchronizer.

Top module: `hsk_out_port`

## Requirements
- R1: After reset, both buffer-full outputs are 1, both interrupt requests are 0, both data outputs are 0, the spare outputs are 0 and the status view reads 8'h82.
- R2: A write with select 0 (A) or 1 (B) loads wr_data onto that channel's data output at the clock edge that samples it. The output holds that value until the next write to the same channel, and a write to one channel leaves the other channel's data unchanged.
- R3: A channel write drives that channel's buffer-full output low and clears its interrupt request at the same edge.
- R4: When acknowledge falls while buffer-full is low, buffer-full returns to 1 at the third rising clock edge that sees the input low. It is still low after the second such edge.
- R5: The rising edge of acknowledge that follows an accepted acknowledge sets the interrupt request at the third clock edge after the input rises, but only when the channel's enable is 1.
- R6: With the channel's enable at 0, the interrupt request stays 0 through a complete handshake.
- R7: An acknowledge pulse that arrives while buffer-full is already 1 changes nothing: buffer-full stays 1 and the interrupt request stays 0.
- R8: A control write (select 3) with bit 7 = 0 writes the value in bit 0 into the status-port bit numbered by bits 3:1. Bit 6 is the enable for A, bit 2 is the enable for B, and bits 4 and 5 drive spare_out[0] and spare_out[1]. The bit numbers 0, 1, 3 and 7 have no effect. Clearing an enable also clears that channel's pending interrupt request.
- R9: A control write with bit 7 = 1 has no effect. A write with select 2 loads wr_data bits 5:4 into spare_out[1:0] and ignores every other bit.
- R10: The status view is {obf_a_n, enable A, spare_out[1], spare_out[0], intr_a, enable B, obf_b_n, intr_b}, most significant bit first.
- R11: When a channel write and an accepted acknowledge fall reach the same clock edge, the write wins: buffer-full stays 0, and the next rising acknowledge raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 = A, 1 = B, 2 = spare bits, 3 = control |
| wr_data | input | 8 | Write data |
| ack_a_n | input | 1 | Asynchronous active-low acknowledge from device A |
| ack_b_n | input | 1 | Asynchronous active-low acknowledge from device B |
| data_a | output | 8 | Latched data for device A |
| data_b | output | 8 | Latched data for device B |
| obf_a_n | output | 1 | Active-low buffer-full toward device A |
| obf_b_n | output | 1 | Active-low buffer-full toward device B |
| intr_a | output | 1 | Interrupt request for the next A byte |
| intr_b | output | 1 | Interrupt request for the next B byte |
| spare_out | output | 2 | General-purpose status-port bits 5:4 |
| status | output | 8 | Packed handshake status view |

## Verification
The properties assume that each acknowledge stays at one level for longer than the synchronizer depth plus one cycle, so that no edge is lost or merged. They also assume that wr_en is asserted for exactly one cycle per write. The stimulus changes acknowledge only on falling clock edges and holds every level for at least three cycles, which keeps it inside those assumptions. Each write strobe lasts a single cycle. Data sweeps cover every byte value on both channels, and the control sweep covers every bit number with both set and clear values.

// File: rtl/hsk_out_pkg.sv
// Shared constants for the strobed output handshake port.
// Assumes an 8-bit status port whose bit positions are fixed by behaviour.
package hsk_out_pkg;
    localparam int NUM_CH   = 2;
    localparam int PC_W     = 8;

    // Write bus select values
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } wr_sel_e;

    // Status-port bit positions
    localparam int PC_OBF_A  = 7;
    localparam int PC_INTE_A = 6;
    localparam int PC_SPR_HI = 5;
    localparam int PC_SPR_LO = 4;
    localparam int PC_INTR_A = 3;
    localparam int PC_INTE_B = 2;
    localparam int PC_OBF_B  = 1;
    localparam int PC_INTR_B = 0;

    // Control byte fields
    localparam int CW_MODE   = 7;
    localparam int CW_SEL_HI = 3;
    localparam int CW_SEL_LO = 1;
    localparam int CW_VAL    = 0;

    // Status-port bit holding the interrupt enable of a channel
    function automatic int inte_bit(input int ch);
        return (ch == 0) ? PC_INTE_A : PC_INTE_B;
    endfunction
endpackage

// File: rtl/hsk_ack_sync.sv
// Synchronizer and edge detector for one asynchronous active-low acknowledge.
// Assumes the input is idle high and each level lasts longer than STAGES+1 clocks.
module hsk_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_async,
    output logic ack_fall,
    output logic ack_rise
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              synced;

    assign synced = chain[STAGES-1];

    // First stage samples the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= ack_n_async;
    end

    // Remaining stages shift the sample along
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b1;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    // Previous synced level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= synced;
    end

    assign ack_fall = prev & ~synced;
    assign ack_rise = ~prev & synced;
endmodule

// File: rtl/hsk_out_channel.sv
// One output channel: data latch, buffer-full flag, interrupt enable and request.
// Assumes wr is a single-cycle strobe and ack edges come from hsk_ack_sync.
module hsk_out_channel #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_n,
    input  logic              inte_we,
    input  logic              inte_val,
    output logic [DATA_W-1:0] data_out,
    output logic              obf_n,
    output logic              intr,
    output logic              inte
);
    logic ack_fall;
    logic ack_rise;
    logic taken;

    hsk_ack_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_async (ack_n),
        .ack_fall    (ack_fall),
        .ack_rise    (ack_rise)
    );

    // Interrupt enable, changed only by bit set/reset writes
    always_ff @(posedge clk) begin
        if (!rst_n)       inte <= 1'b0;
        else if (inte_we) inte <= inte_val;
    end

    // Data latch loads on every channel write
    always_ff @(posedge clk) begin
        if (!rst_n)  data_out <= '0;
        else if (wr) data_out <= wr_data;
    end

    // Handshake state: write arms, acknowledge fall releases, rise requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf_n <= 1'b1;
            taken <= 1'b0;
            intr  <= 1'b0;
        end else begin
            if (wr) begin
                obf_n <= 1'b0;
                taken <= 1'b0;
                intr  <= 1'b0;
            end else begin
                if (ack_fall && !obf_n) begin
                    obf_n <= 1'b1;
                    taken <= 1'b1;
                end
                if (ack_rise && taken) begin
                    taken <= 1'b0;
                    if (inte) intr <= 1'b1;
                end
            end
            if (inte_we && !inte_val) intr <= 1'b0;
        end
    end
endmodule

// File: rtl/hsk_bus_decode.sv
// Decodes the CPU write bus into channel writes, enable updates and spare bits.
// Assumes wr_en is a single-cycle strobe; mode bytes (bit 7 set) are discarded.
module hsk_bus_decode
    import hsk_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PC_W-1:0]   wr_data,
    output logic [NUM_CH-1:0] ch_wr,
    output logic [NUM_CH-1:0] inte_we,
    output logic              inte_val,
    output logic [1:0]        spare
);
    localparam int BIT_SEL_W = CW_SEL_HI - CW_SEL_LO + 1;

    logic                 bsr_wr;
    logic [BIT_SEL_W-1:0] bsr_bit;

    assign bsr_wr   = wr_en && (wr_sel == SEL_CTRL) && !wr_data[CW_MODE];
    assign bsr_bit  = wr_data[CW_SEL_HI:CW_SEL_LO];
    assign inte_val = wr_data[CW_VAL];

    // Channel data writes and enable strobes
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign ch_wr[c]   = wr_en && (wr_sel == 2'(c));
            assign inte_we[c] = bsr_wr && (bsr_bit == BIT_SEL_W'(inte_bit(c)));
        end
    endgenerate

    // Spare bits: whole-port write or single-bit set/reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare <= 2'b00;
        end else if (wr_en && (wr_sel == SEL_PC)) begin
            spare <= wr_data[PC_SPR_HI:PC_SPR_LO];
        end else if (bsr_wr && (bsr_bit == BIT_SEL_W'(PC_SPR_LO))) begin
            spare[0] <= wr_data[CW_VAL];
        end else if (bsr_wr && (bsr_bit == BIT_SEL_W'(PC_SPR_HI))) begin
            spare[1] <= wr_data[CW_VAL];
        end
    end
endmodule

// File: rtl/hsk_out_port.sv
// Two strobed output handshake channels sharing one CPU write bus and a status view.
// Assumes acknowledges are asynchronous, idle high, and wr_en is one cycle per write.
module hsk_out_port
    import hsk_out_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PC_W-1:0]   wr_data,
    input  logic              ack_a_n,
    input  logic              ack_b_n,
    output logic [DATA_W-1:0] data_a,
    output logic [DATA_W-1:0] data_b,
    output logic              obf_a_n,
    output logic              obf_b_n,
    output logic              intr_a,
    output logic              intr_b,
    output logic [1:0]        spare_out,
    output logic [PC_W-1:0]   status
);
    logic [NUM_CH-1:0]             ch_wr;
    logic [NUM_CH-1:0]             inte_we;
    logic                          inte_val;
    logic [NUM_CH-1:0]             ack_n;
    logic [NUM_CH-1:0][DATA_W-1:0] dout;
    logic [NUM_CH-1:0]             obf_n;
    logic [NUM_CH-1:0]             intr;
    logic [NUM_CH-1:0]             inte;

    hsk_bus_decode i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ch_wr    (ch_wr),
        .inte_we  (inte_we),
        .inte_val (inte_val),
        .spare    (spare_out)
    );

    assign ack_n = {ack_b_n, ack_a_n};

    // One handshake channel per port
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            hsk_out_channel #(
                .DATA_W      (DATA_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) i_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (ch_wr[c]),
                .wr_data  (wr_data[DATA_W-1:0]),
                .ack_n    (ack_n[c]),
                .inte_we  (inte_we[c]),
                .inte_val (inte_val),
                .data_out (dout[c]),
                .obf_n    (obf_n[c]),
                .intr     (intr[c]),
                .inte     (inte[c])
            );
        end
    endgenerate

    assign data_a  = dout[0];
    assign data_b  = dout[1];
    assign obf_a_n = obf_n[0];
    assign obf_b_n = obf_n[1];
    assign intr_a  = intr[0];
    assign intr_b  = intr[1];

    // Status view assembly
    always_comb begin
        status            = '0;
        status[PC_OBF_A]  = obf_n[0];
        status[PC_INTE_A] = inte[0];
        status[PC_SPR_HI] = spare_out[1];
        status[PC_SPR_LO] = spare_out[0];
        status[PC_INTR_A] = intr[0];
        status[PC_INTE_B] = inte[1];
        status[PC_OBF_B]  = obf_n[1];
        status[PC_INTR_B] = intr[1];
    end
endmodule

// File: rtl/hsk_out_port_chk.sv
// Protocol checker for hsk_out_port, attached through bind; observes ports only.
module hsk_out_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] data_a,
    input logic [7:0] data_b,
    input logic       obf_a_n,
    input logic       obf_b_n,
    input logic       intr_a,
    input logic       intr_b,
    input logic [7:0] status
);
    p_obf_low_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (!obf_a_n && !intr_a));

    p_obf_b_low_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (!obf_b_n && !intr_b));

    p_data_a_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd0) |=> $stable(data_a));

    p_data_b_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd1) |=> $stable(data_b));

    p_obf_falls_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf_a_n) |-> $past(wr_en && wr_sel == 2'd0));

    p_intr_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_a |-> status[6]) and (intr_b |-> status[2]));

    p_intr_only_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(intr_a) |-> obf_a_n) and ($rose(intr_b) |-> obf_b_n));
endmodule

bind hsk_out_port hsk_out_port_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .data_a  (data_a),
    .data_b  (data_b),
    .obf_a_n (obf_a_n),
    .obf_b_n (obf_b_n),
    .intr_a  (intr_a),
    .intr_b  (intr_b),
    .status  (status)
);

// File: tb/test_hsk_out_port.sv
module test_hsk_out_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ack_a_n = 1'b1;
    logic       ack_b_n = 1'b1;
    logic [7:0] data_a, data_b, status;
    logic       obf_a_n, obf_b_n, intr_a, intr_b;
    logic [1:0] spare_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of observable state
    logic [7:0] m_da = 0, m_db = 0;
    logic       m_obf_a = 1, m_obf_b = 1, m_ia = 0, m_ib = 0, m_ea = 0, m_eb = 0;
    logic [1:0] m_sp = 0;

    always #5 clk = ~clk;

    hsk_out_port i_hsk_out_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ack_a_n(ack_a_n), .ack_b_n(ack_b_n), .data_a(data_a), .data_b(data_b),
        .obf_a_n(obf_a_n), .obf_b_n(obf_b_n), .intr_a(intr_a), .intr_b(intr_b),
        .spare_out(spare_out), .status(status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_obf_a, m_ea, m_sp[1], m_sp[0], m_ia, m_eb, m_obf_b, m_ib};
    endfunction

    task automatic check_all(input string req);
        check({req, " data_a"}, data_a, m_da);
        check({req, " data_b"}, data_b, m_db);
        check({req, " spare"}, {6'd0, spare_out}, {6'd0, m_sp});
        check({req, " status R10"}, status, m_status());
    endtask

    task automatic cpu_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: begin m_da = d; m_obf_a = 0; m_ia = 0; end
            2'd1: begin m_db = d; m_obf_b = 0; m_ib = 0; end
            2'd2: m_sp = d[5:4];
            default: if (!d[7]) begin
                case (d[3:1])
                    3'd6: begin m_ea = d[0]; if (!d[0]) m_ia = 0; end
                    3'd2: begin m_eb = d[0]; if (!d[0]) m_ib = 0; end
                    3'd4: m_sp[0] = d[0];
                    3'd5: m_sp[1] = d[0];
                    default: ;
                endcase
            end
        endcase
    endtask

    // Full acknowledge pulse on channel ch; model updates per R4/R5
    task automatic ack_pulse(input int ch, input string req);
        logic was_full;
        was_full = (ch == 0) ? !m_obf_a : !m_obf_b;
        @(negedge clk);
        if (ch == 0) ack_a_n = 1'b0; else ack_b_n = 1'b0;
        repeat (3) @(negedge clk);
        if (was_full) begin
            if (ch == 0) m_obf_a = 1; else m_obf_b = 1;
        end
        check_all({req, " after ack fall"});
        if (ch == 0) ack_a_n = 1'b1; else ack_b_n = 1'b1;
        repeat (3) @(negedge clk);
        if (was_full) begin
            if (ch == 0) m_ia = m_ea; else m_ib = m_eb;
        end
        check_all({req, " after ack rise"});
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status, 8'h82);
        check("R1 intr", {6'd0, intr_a, intr_b}, 8'd0);
        check_all("R1");

        // R7: acknowledge with buffer already empty, enable on
        cpu_wr(2'd3, 8'h0D);
        cpu_wr(2'd3, 8'h05);
        ack_pulse(0, "R7 A");
        ack_pulse(1, "R7 B");
        check("R7 intr", {6'd0, intr_a, intr_b}, 8'd0);

        // R2: every data value on both channels
        for (int v = 0; v < 256; v++) begin
            cpu_wr(2'd0, 8'(v));
            check("R2 A data", data_a, 8'(v));
            check("R3 A obf", {7'd0, obf_a_n}, 8'd0);
            cpu_wr(2'd1, 8'(255 - v));
            check("R2 B data", data_b, 8'(255 - v));
            check("R2 A held", data_a, 8'(v));
        end

        // R4 exact timing on channel A
        @(negedge clk);
        ack_a_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 obf still low", {7'd0, obf_a_n}, 8'd0);
        @(negedge clk);
        check("R4 obf high", {7'd0, obf_a_n}, 8'd1);
        m_obf_a = 1;
        ack_a_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 intr not yet", {7'd0, intr_a}, 8'd0);
        @(negedge clk);
        check("R5 intr set", {7'd0, intr_a}, 8'd1);
        m_ia = 1;
        check_all("R5");

        // R3: a write clears the pending request
        cpu_wr(2'd0, 8'h3C);
        check("R3 intr cleared", {7'd0, intr_a}, 8'd0);
        ack_pulse(0, "R5 A");
        ack_pulse(1, "R5 B");

        // R8: clearing enable drops pending request
        cpu_wr(2'd3, 8'h0C);
        check("R8 intr dropped", {7'd0, intr_a}, 8'd0);
        check_all("R8 clear enable");

        // R6: handshakes with enables off
        cpu_wr(2'd3, 8'h04);
        for (int k = 0; k < 4; k++) begin
            cpu_wr(2'd0, 8'(k * 37));
            ack_pulse(0, "R6 A");
            cpu_wr(2'd1, 8'(k * 53));
            ack_pulse(1, "R6 B");
        end
        check("R6 intr", {6'd0, intr_a, intr_b}, 8'd0);

        // R11: write and accepted acknowledge fall at the same edge
        cpu_wr(2'd3, 8'h0D);
        cpu_wr(2'd0, 8'h11);
        @(negedge clk);
        ack_a_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h22;
        @(negedge clk);
        wr_en = 1'b0;
        m_da = 8'h22;
        check("R11 obf stays low", {7'd0, obf_a_n}, 8'd0);
        repeat (2) @(negedge clk);
        ack_a_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 no request", {7'd0, intr_a}, 8'd0);
        check_all("R11");
        ack_pulse(0, "R11 recovery");

        // R8 / R9: every set/reset bit number, both values, plus mode bytes
        for (int b = 0; b < 8; b++) begin
            for (int val = 1; val >= 0; val--) begin
                cpu_wr(2'd3, {4'd0, 3'(b), 1'(val)});
                check_all("R8 bit set/reset");
            end
        end
        cpu_wr(2'd3, 8'h0B);
        cpu_wr(2'd3, 8'h8D);
        cpu_wr(2'd3, 8'hFF);
        check_all("R9 mode byte ignored");
        for (int v = 0; v < 256; v += 17) begin
            cpu_wr(2'd2, 8'(v));
            check_all("R9 spare write");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule